// File: doc/BRIEF.md
# Folded Self-Aligned Dot-Product Unit

The block forms the dot product of two vectors whose elements are held in a self-aligned floating form. Each element is a triple: a reduced exponent, a small left-shift field (`lsh`) and a signed two's-complement mantissa. The value of an element is its mantissa scaled by a power of two. That power comes from the reduced exponent times 2^L, plus the low-order part that the shift field carries. The block has only NL multiply lanes. A vector of N elements is therefore presented as a sequence of chunks, each holding NL element pairs, at most one chunk per clock. The last chunk of a vector is marked with a flag.

Every chunk passes through NL multipliers and then through one NL-input aligned adder. The adder produces a partial dot product. An accumulator merges these partial results into a running sum. The running sum is always kept relative to the larger of the two exponents involved, so no renormalisation step is needed. After the last chunk, the block raises a one-cycle result strobe together with the final exponent, shift field and wide mantissa. Setting NL equal to N turns the block into the fully parallel form, in which each vector is a single chunk. Packing to or from a standard floating-point encoding, and rounding, are left to neighbouring logic.

Top module: `sadp_dot`

## Requirements
- R1: For each lane, the product's combined exponent {p_exp, p_lsh} equals {a_exp, a_lsh} + {b_exp, b_lsh} − B, where B = 2^(WE+L−1) − 1. The reduced exponent is the upper WE bits of that value and the shift field is its lower L bits.
- R2: Each lane's product mantissa equals (a_man << a_lsh) × (b_man << b_lsh), computed in signed two's complement with no truncation.
- R3: The partial sum of a chunk takes as reference the lane with the largest product exponent, with the lowest lane index winning a tie. Every lane mantissa is arithmetically shifted right by (reference exponent − lane exponent)·2^L and the results are added. The partial result carries the exponent and shift field of the reference lane.
- R4: The first chunk of a vector loads the accumulator. Each later chunk is merged using the larger of the two exponents as reference, with the running sum winning a tie. The other mantissa is arithmetically shifted right by the exponent difference times 2^L, and the reference's exponent and shift field are kept. The accumulator does not change in cycles with no partial result.
- R5: res_valid is high for exactly one cycle, beginning two clock edges after the edge that accepts the last chunk. A vector of C chunks therefore takes C + 2 cycles from its first chunk to its result.
- R6: busy rises on the edge that accepts the first chunk of a vector and stays high until it falls on the edge that raises res_valid. busy is never high while res_valid is high.
- R7: A chunk offered after the last chunk has been accepted, but before res_valid, is ignored and does not change the result.
- R8: After a synchronous active-low reset, busy, res_valid, res_exp, res_lsh and res_man are all zero.
- R9: A new vector may begin in the cycle in which res_valid is high. Its result does not depend on any earlier vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chunk_valid | input | 1 | A chunk of NL element pairs is offered |
| chunk_last | input | 1 | The offered chunk ends the vector |
| a_exp | input | NL*WE | Reduced exponents of the first operands, lane i at [i*WE +: WE] |
| a_lsh | input | NL*L | Shift fields of the first operands |
| a_man | input | NL*WM | Signed mantissas of the first operands |
| b_exp | input | NL*WE | Reduced exponents of the second operands |
| b_lsh | input | NL*L | Shift fields of the second operands |
| b_man | input | NL*WM | Signed mantissas of the second operands |
| busy | output | 1 | A vector is open or still in the pipeline |
| res_valid | output | 1 | One-cycle strobe marking a finished dot product |
| res_exp | output | WE | Reduced exponent of the result |
| res_lsh | output | L | Shift field of the result |
| res_man | output | SW+clog2(N/NL) | Signed result mantissa, SW = 2*(WM+2^L−1)+clog2(NL) |

## Verification
The assertions assume that each accepted operand pair gives a combined exponent sum inside [B, B + 2^(WE+L) − 1]. Under that assumption the product exponent neither wraps below zero nor past the top of its field. They also assume the caller offers no new chunk between a last chunk and its result, apart from the deliberate extra offers that the drain check makes. The stimulus draws operand reduced exponents only from 4 to 11 and keeps mantissas within their declared width. This keeps every combined sum between 32 and 94, and every accumulated magnitude below the result width. Vectors never hold more than N/NL chunks.

// File: rtl/sadp_pkg.sv
// Shared types for the folded self-aligned dot-product unit.
package sadp_pkg;

    // Vector-level control state of the folded datapath.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no vector open
        ST_OPEN  = 2'd1,   // at least one chunk taken, last not yet seen
        ST_DRAIN = 2'd2    // last chunk taken, result still in flight
    } fold_state_e;

endpackage

// File: rtl/sadp_mul_lane.sv
// One self-aligned multiplier lane (combinational).
// Adds the concatenated {exponent, lsh} pairs and removes one bias.
// Multiplies the two mantissas after widening each one by its own lsh.
// Assumes the caller keeps the biased sum inside the exponent field range.
module sadp_mul_lane #(
    parameter int WE = 4,
    parameter int L  = 2,
    parameter int WM = 6,
    parameter int PW = 2 * (WM + (2 ** L) - 1)
) (
    input  logic [WE-1:0] a_exp,
    input  logic [L-1:0]  a_lsh,
    input  logic [WM-1:0] a_man,
    input  logic [WE-1:0] b_exp,
    input  logic [L-1:0]  b_lsh,
    input  logic [WM-1:0] b_man,
    output logic [WE-1:0] p_exp,
    output logic [L-1:0]  p_lsh,
    output logic [PW-1:0] p_man
);
    localparam int EW = WE + L;
    localparam int XW = WM + (2 ** L) - 1;
    localparam logic [EW-1:0] BIAS_N = EW'((2 ** (EW - 1)) - 1);

    logic [EW-1:0]        esum;
    logic signed [XW-1:0] a_ext;
    logic signed [XW-1:0] b_ext;

    // Combined exponent: concatenate, add, remove the single bias.
    assign esum  = {a_exp, a_lsh} + {b_exp, b_lsh} - BIAS_N;
    assign p_exp = esum[EW-1:L];
    assign p_lsh = esum[L-1:0];

    // Mantissa widening by each operand's own shift field.
    assign a_ext = XW'($signed(a_man)) <<< a_lsh;
    assign b_ext = XW'($signed(b_man)) <<< b_lsh;

    // Full-width signed product.
    assign p_man = a_ext * b_ext;

endmodule

// File: rtl/sadp_chunk_sum.sv
// Aligned NL-input adder for one chunk of products, registered output.
// Finds the lane with the largest reduced exponent (lowest index wins a tie).
// Shifts every lane right by the exponent gap times 2^L, then sums.
// Assumes products are signed PW-bit values; the output grows by clog2(NL) bits.
module sadp_chunk_sum #(
    parameter int WE = 4,
    parameter int L  = 2,
    parameter int NL = 2,
    parameter int PW = 18,
    parameter int SW = PW + $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [NL*WE-1:0] p_exp,
    input  logic [NL*L-1:0]  p_lsh,
    input  logic [NL*PW-1:0] p_man,
    output logic             out_valid,
    output logic             out_last,
    output logic [WE-1:0]    out_exp,
    output logic [L-1:0]     out_lsh,
    output logic [SW-1:0]    out_man
);
    localparam int EW = WE + L;

    logic [WE-1:0]        ref_e;
    logic [L-1:0]         ref_l;
    logic [WE-1:0]        lane_e;
    logic [WE-1:0]        lane_gap;
    logic signed [SW-1:0] lane_m;
    logic signed [SW-1:0] sum_c;

    // Reference search: strictly-greater compare keeps the lowest lane on ties.
    always_comb begin
        ref_e = p_exp[WE-1:0];
        ref_l = p_lsh[L-1:0];
        for (int i = 1; i < NL; i++) begin
            if (p_exp[i*WE +: WE] > ref_e) begin
                ref_e = p_exp[i*WE +: WE];
                ref_l = p_lsh[i*L +: L];
            end
        end
    end

    // Alignment and integer summation of all lanes.
    always_comb begin
        sum_c    = '0;
        lane_e   = '0;
        lane_gap = '0;
        lane_m   = '0;
        for (int i = 0; i < NL; i++) begin
            lane_e   = p_exp[i*WE +: WE];
            lane_gap = ref_e - lane_e;
            lane_m   = SW'($signed(p_man[i*PW +: PW]));
            sum_c    = sum_c + (lane_m >>> EW'({lane_gap, {L{1'b0}}}));
        end
    end

    // Output register of the partial dot product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_exp   <= '0;
            out_lsh   <= '0;
            out_man   <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            out_exp   <= ref_e;
            out_lsh   <= ref_l;
            out_man   <= sum_c;
        end
    end

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (out_valid && out_last)); // R5

endmodule

// File: rtl/sadp_acc.sv
// Self-aligned running accumulator for partial dot products.
// The first partial result of a vector loads the sum. Later ones merge
// against the larger exponent (the running sum wins a tie). Raises a
// one-cycle result strobe on the edge that absorbs the last partial result.
// Assumes at most N/NL partial results per vector, so AW bits cannot overflow.
module sadp_acc #(
    parameter int WE = 4,
    parameter int L  = 2,
    parameter int SW = 19,
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [WE-1:0] in_exp,
    input  logic [L-1:0]  in_lsh,
    input  logic [SW-1:0] in_man,
    output logic          res_valid,
    output logic [WE-1:0] res_exp,
    output logic [L-1:0]  res_lsh,
    output logic [AW-1:0] res_man
);
    localparam int EW = WE + L;

    logic                 first_q;
    logic [WE-1:0]        acc_e;
    logic [L-1:0]         acc_l;
    logic signed [AW-1:0] acc_m;
    logic signed [AW-1:0] in_ext;
    logic [WE-1:0]        gap;
    logic [WE-1:0]        nxt_e;
    logic [L-1:0]         nxt_l;
    logic signed [AW-1:0] nxt_m;

    assign in_ext = AW'($signed(in_man));

    // Merge rule: load on the first chunk, else align to the larger exponent.
    always_comb begin
        gap   = '0;
        nxt_e = acc_e;
        nxt_l = acc_l;
        nxt_m = acc_m;
        if (first_q) begin
            nxt_e = in_exp;
            nxt_l = in_lsh;
            nxt_m = in_ext;
        end else if (in_exp > acc_e) begin
            gap   = in_exp - acc_e;
            nxt_e = in_exp;
            nxt_l = in_lsh;
            nxt_m = (acc_m >>> EW'({gap, {L{1'b0}}})) + in_ext;
        end else begin
            gap   = acc_e - in_exp;
            nxt_m = acc_m + (in_ext >>> EW'({gap, {L{1'b0}}}));
        end
    end

    // Running-sum registers, the first-chunk marker and the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b1;
            acc_e     <= '0;
            acc_l     <= '0;
            acc_m     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid && in_last;
            if (in_valid) begin
                first_q <= in_last;
                acc_e   <= nxt_e;
                acc_l   <= nxt_l;
                acc_m   <= nxt_m;
            end
        end
    end

    assign res_exp = acc_e;
    assign res_lsh = acc_l;
    assign res_man = acc_m;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_m)); // R4

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R5

endmodule

// File: rtl/sadp_dot.sv
// Folded self-aligned dot-product unit (top).
// Takes one chunk of NL element pairs per cycle, multiplies them in NL lanes,
// reduces them to one aligned partial result and accumulates it.
// Pipeline: operand edge -> product register -> chunk sum register -> accumulator.
// Assumes operand exponents keep each product exponent in range, and assumes
// N is a multiple of NL.
module sadp_dot
    import sadp_pkg::*;
#(
    parameter int WE = 4,
    parameter int L  = 2,
    parameter int WM = 6,
    parameter int N  = 8,
    parameter int NL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chunk_valid,
    input  logic             chunk_last,
    input  logic [NL*WE-1:0] a_exp,
    input  logic [NL*L-1:0]  a_lsh,
    input  logic [NL*WM-1:0] a_man,
    input  logic [NL*WE-1:0] b_exp,
    input  logic [NL*L-1:0]  b_lsh,
    input  logic [NL*WM-1:0] b_man,
    output logic             busy,
    output logic             res_valid,
    output logic [WE-1:0]    res_exp,
    output logic [L-1:0]     res_lsh,
    output logic [2*(WM+(2**L)-1)+$clog2(NL)+$clog2(N/NL)-1:0] res_man
);
    localparam int NCH = N / NL;
    localparam int EW  = WE + L;
    localparam int PW  = 2 * (WM + (2 ** L) - 1);
    localparam int SW  = PW + $clog2(NL);
    localparam int AW  = SW + $clog2(NCH);
    localparam logic [EW:0] SUM_LO = (EW + 1)'((2 ** (EW - 1)) - 1);
    localparam logic [EW:0] SUM_HI = (EW + 1)'((2 ** (EW - 1)) - 1 + (2 ** EW) - 1);

    fold_state_e      state_q;
    logic             accept;
    logic [NL*WE-1:0] m_exp;
    logic [NL*L-1:0]  m_lsh;
    logic [NL*PW-1:0] m_man;
    logic             s1_valid;
    logic             s1_last;
    logic [NL*WE-1:0] s1_exp;
    logic [NL*L-1:0]  s1_lsh;
    logic [NL*PW-1:0] s1_man;
    logic             s2_valid;
    logic             s2_last;
    logic [WE-1:0]    s2_exp;
    logic [L-1:0]     s2_lsh;
    logic [SW-1:0]    s2_man;

    // Chunks are taken unless the current vector is draining.
    assign accept = chunk_valid && (state_q != ST_DRAIN);
    assign busy   = (state_q != ST_IDLE);

    // Vector control: open on a chunk, drain after the last one, close at the result edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= chunk_last ? ST_DRAIN : ST_OPEN;
        end else if ((state_q == ST_DRAIN) && s2_valid && s2_last) begin
            state_q <= ST_IDLE;
        end
    end

    // The NL multiplier lanes; only this one set exists and every chunk reuses it.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [EW:0] raw_sum;

        sadp_mul_lane #(
            .WE(WE), .L(L), .WM(WM), .PW(PW)
        ) u_mul (
            .a_exp(a_exp[g*WE +: WE]),
            .a_lsh(a_lsh[g*L +: L]),
            .a_man(a_man[g*WM +: WM]),
            .b_exp(b_exp[g*WE +: WE]),
            .b_lsh(b_lsh[g*L +: L]),
            .b_man(b_man[g*WM +: WM]),
            .p_exp(m_exp[g*WE +: WE]),
            .p_lsh(m_lsh[g*L +: L]),
            .p_man(m_man[g*PW +: PW])
        );

        assign raw_sum = {1'b0, a_exp[g*WE +: WE], a_lsh[g*L +: L]}
                       + {1'b0, b_exp[g*WE +: WE], b_lsh[g*L +: L]};

        AST_PROD_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            accept |-> ((raw_sum >= SUM_LO) && (raw_sum <= SUM_HI))); // R1
    end

    // Product register between the lanes and the aligned adder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_exp   <= '0;
            s1_lsh   <= '0;
            s1_man   <= '0;
        end else begin
            s1_valid <= accept;
            s1_last  <= accept && chunk_last;
            s1_exp   <= m_exp;
            s1_lsh   <= m_lsh;
            s1_man   <= m_man;
        end
    end

    sadp_chunk_sum #(
        .WE(WE), .L(L), .NL(NL), .PW(PW), .SW(SW)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s1_valid),
        .in_last  (s1_last),
        .p_exp    (s1_exp),
        .p_lsh    (s1_lsh),
        .p_man    (s1_man),
        .out_valid(s2_valid),
        .out_last (s2_last),
        .out_exp  (s2_exp),
        .out_lsh  (s2_lsh),
        .out_man  (s2_man)
    );

    sadp_acc #(
        .WE(WE), .L(L), .SW(SW), .AW(AW)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s2_valid),
        .in_last  (s2_last),
        .in_exp   (s2_exp),
        .in_lsh   (s2_lsh),
        .in_man   (s2_man),
        .res_valid(res_valid),
        .res_exp  (res_exp),
        .res_lsh  (res_lsh),
        .res_man  (res_man)
    );

    AST_BUSY_CLEAR_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy); // R6

    AST_DRAIN_IGNORES_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && chunk_valid) |=> !s1_valid); // R7

endmodule

// File: tb/test_sadp_dot.sv
// Scoreboard bench for sadp_dot: the driver computes each vector's expected
// result and pushes it into a queue; the monitor pops and compares on res_valid.
module test_sadp_dot;
    localparam int CLK_P = 10;
    localparam int WE    = 4;
    localparam int L     = 2;
    localparam int WM    = 6;
    localparam int N     = 8;
    localparam int NL    = 2;
    localparam int MAXCH = N / NL;
    localparam int PW    = 2 * (WM + (2 ** L) - 1);
    localparam int SW    = PW + $clog2(NL);
    localparam int AW    = SW + $clog2(MAXCH);
    localparam int BIAS  = (2 ** (WE + L - 1)) - 1;

    logic             clk;
    logic             rst_n;
    logic             chunk_valid;
    logic             chunk_last;
    logic [NL*WE-1:0] a_exp;
    logic [NL*L-1:0]  a_lsh;
    logic [NL*WM-1:0] a_man;
    logic [NL*WE-1:0] b_exp;
    logic [NL*L-1:0]  b_lsh;
    logic [NL*WM-1:0] b_man;
    logic             busy;
    logic             res_valid;
    logic [WE-1:0]    res_exp;
    logic [L-1:0]     res_lsh;
    logic [AW-1:0]    res_man;

    sadp_dot #(.WE(WE), .L(L), .WM(WM), .N(N), .NL(NL)) i_sadp_dot (
        .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_last(chunk_last),
        .a_exp(a_exp), .a_lsh(a_lsh), .a_man(a_man),
        .b_exp(b_exp), .b_lsh(b_lsh), .b_man(b_man),
        .busy(busy), .res_valid(res_valid), .res_exp(res_exp),
        .res_lsh(res_lsh), .res_man(res_man)
    );

    int ae [MAXCH][NL];
    int al [MAXCH][NL];
    int am [MAXCH][NL];
    int be [MAXCH][NL];
    int bl [MAXCH][NL];
    int bm [MAXCH][NL];

    int checks;
    int errors;
    int cyc;
    bit finished;
    int unsigned seed;

    int     q_e[$];
    int     q_l[$];
    int     q_c[$];
    longint q_m[$];
    string  q_t[$];

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(int span);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) & 32'h00FF_FFFF) % span;
    endfunction

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model built from R1..R4.
    task automatic model(input int nch, output int oe, output int ol, output longint om);
        int     acc_e;
        int     acc_l;
        longint acc_m;
        acc_e = 0; acc_l = 0; acc_m = 0;
        for (int c = 0; c < nch; c++) begin
            int     pe [NL];
            int     pl [NL];
            longint pm [NL];
            int     ce;
            int     cl;
            longint cm;
            for (int i = 0; i < NL; i++) begin
                int s;
                s = ae[c][i] * (2 ** L) + al[c][i] + be[c][i] * (2 ** L) + bl[c][i] - BIAS;
                pe[i] = s / (2 ** L);
                pl[i] = s % (2 ** L);
                pm[i] = longint'(am[c][i] * (2 ** al[c][i])) * longint'(bm[c][i] * (2 ** bl[c][i]));
            end
            ce = pe[0]; cl = pl[0];
            for (int i = 1; i < NL; i++) begin
                if (pe[i] > ce) begin
                    ce = pe[i];
                    cl = pl[i];
                end
            end
            cm = 0;
            for (int i = 0; i < NL; i++) cm = cm + (pm[i] >>> ((ce - pe[i]) * (2 ** L)));
            if (c == 0) begin
                acc_e = ce; acc_l = cl; acc_m = cm;
            end else if (ce > acc_e) begin
                acc_m = (acc_m >>> ((ce - acc_e) * (2 ** L))) + cm;
                acc_e = ce; acc_l = cl;
            end else begin
                acc_m = acc_m + (cm >>> ((acc_e - ce) * (2 ** L)));
            end
        end
        oe = acc_e; ol = acc_l; om = acc_m;
    endtask

    task automatic fill_random(int nch);
        for (int c = 0; c < nch; c++) begin
            for (int i = 0; i < NL; i++) begin
                ae[c][i] = 4 + rnd(8); al[c][i] = rnd(4); am[c][i] = rnd(64) - 32;
                be[c][i] = 4 + rnd(8); bl[c][i] = rnd(4); bm[c][i] = rnd(64) - 32;
            end
        end
    endtask

    // Equal product exponents with different shift fields (tie goes to lane 0).
    task automatic fill_ties();
        ae[0][0] = 6; al[0][0] = 0; am[0][0] = 5;  be[0][0] = 5; bl[0][0] = 3; bm[0][0] = 3;
        ae[0][1] = 6; al[0][1] = 3; am[0][1] = -3; be[0][1] = 5; bl[0][1] = 3; bm[0][1] = -7;
    endtask

    // Widely spread chunk exponents so that small partial sums are flushed.
    task automatic fill_spread();
        int ex [MAXCH];
        ex[0] = 4; ex[1] = 11; ex[2] = 8; ex[3] = 11;
        for (int c = 0; c < MAXCH; c++) begin
            for (int i = 0; i < NL; i++) begin
                ae[c][i] = ex[c % 4]; al[c][i] = rnd(4); am[c][i] = -1 - rnd(32);
                be[c][i] = ex[c % 4]; bl[c][i] = rnd(4); bm[c][i] = rnd(64) - 32;
            end
        end
    endtask

    task automatic drive_chunk(int c, bit last);
        chunk_valid = 1'b1;
        chunk_last  = last;
        for (int i = 0; i < NL; i++) begin
            a_exp[i*WE +: WE] = WE'(ae[c][i]);
            a_lsh[i*L +: L]   = L'(al[c][i]);
            a_man[i*WM +: WM] = WM'(am[c][i]);
            b_exp[i*WE +: WE] = WE'(be[c][i]);
            b_lsh[i*L +: L]   = L'(bl[c][i]);
            b_man[i*WM +: WM] = WM'(bm[c][i]);
        end
    endtask

    // Driver: called at a falling edge; feeds one vector and pushes its expectation.
    task automatic run_vector(string tag, int nch, bit poke, int gap);
        int     oe;
        int     ol;
        longint om;
        model(nch, oe, ol, om);
        for (int c = 0; c < nch; c++) begin
            drive_chunk(c, c == nch - 1);
            @(posedge clk);
            #1;
            if (c == 0) check_eq({tag, " R6 busy after first chunk"}, busy, 1);
            if (c == nch - 1) begin
                q_e.push_back(oe); q_l.push_back(ol); q_m.push_back(om);
                q_c.push_back(cyc + 2); q_t.push_back(tag);
            end
            @(negedge clk);
        end
        if (poke) begin
            chunk_valid = 1'b1;
            chunk_last  = 1'b1;
            a_man = '1; b_man = '1; a_exp = '1; b_exp = '1; a_lsh = '0; b_lsh = '0;
            check_eq({tag, " R6 R7 busy while draining"}, busy, 1);
            @(negedge clk);
        end
        chunk_valid = 1'b0;
        chunk_last  = 1'b0;
        while (!res_valid) @(negedge clk);
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: compares every result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_e.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected result actual=1 expected=0");
            end else begin
                string tag;
                tag = q_t.pop_front();
                check_eq({tag, " R1 R3 R4 result exponent"}, res_exp, q_e.pop_front());
                check_eq({tag, " R1 R3 R4 result lsh"}, res_lsh, q_l.pop_front());
                check_eq({tag, " R2 R3 R4 result mantissa"}, longint'($signed(res_man)), q_m.pop_front());
                check_eq({tag, " R5 result cycle"}, cyc, q_c.pop_front());
                check_eq({tag, " R6 busy low with result"}, busy, 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; cyc = 0; finished = 1'b0; seed = 32'h2468ACE1;
        rst_n = 1'b0; chunk_valid = 1'b0; chunk_last = 1'b0;
        a_exp = '0; a_lsh = '0; a_man = '0; b_exp = '0; b_lsh = '0; b_man = '0;
        repeat (3) @(negedge clk);
        check_eq("R8 busy in reset", busy, 0);
        check_eq("R8 res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R8 res_valid after reset", res_valid, 0);
        check_eq("R8 busy after reset", busy, 0);
        check_eq("R8 res_exp after reset", res_exp, 0);
        check_eq("R8 res_lsh after reset", res_lsh, 0);
        check_eq("R8 res_man after reset", res_man, 0);

        fill_ties();      run_vector("R3 tie", 1, 1'b0, 2);
        fill_random(4);   run_vector("full", 4, 1'b0, 1);
        fill_spread();    run_vector("R4 spread", 4, 1'b0, 1);
        fill_random(3);   run_vector("R7 drain", 3, 1'b1, 0);
        fill_random(2);   run_vector("R9 back", 2, 1'b0, 0);
        fill_random(1);   run_vector("R9 single", 1, 1'b0, 0);
        fill_random(4);   run_vector("R9 R7 back", 4, 1'b1, 0);
        for (int v = 0; v < 24; v++) begin
            int nch;
            nch = 1 + rnd(MAXCH);
            fill_random(nch);
            run_vector("random", nch, rnd(2) == 1, rnd(3));
        end

        repeat (5) @(negedge clk);
        check_eq("R5 pending results", q_e.size(), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule